// File: doc/BRIEF.md
# Halfword-to-Word Register Access Bridge

This bridge sits between a host bus that issues either 16-bit or 32-bit accesses and a register file that only understands whole 32-bit words. Many registers in such a file have side effects: reading a data port pops a queue, and writing one pushes an entry. A naive split of each word into two halfword accesses would fire those side effects twice. The bridge avoids that. It gathers two halfword writes aimed at one word into a single 32-bit write. For halfword reads, it fetches the word once and answers both halves from a holding latch.

Full 32-bit accesses bypass the pairing logic in either bus mode. A strap input selects whether the host bus is narrow (16-bit) or wide (32-bit). The bridge owns one configuration register. That register reports the strapped mode in one bit, keeps a small set of writable bits, and triggers a soft reset of the pairing state when its lowest bit is written as one. The downstream side is a single-cycle strobe interface. Write and read strobes are asserted in the same cycle as the host request. The register file returns read data combinationally, and the host sees read data one cycle after its request.

Top module: `halfword_bridge`

## Requirements
- R1: A 4-byte write (h_size = 4) to any word other than the configuration word asserts d_wr for exactly the request cycle, with d_wdata equal to h_wdata and d_addr equal to the low 8 address bits with bits 1:0 cleared. Address bits above bit 7 are ignored.
- R2: A 4-byte read to any word other than the configuration word asserts d_rd in the request cycle. In the following cycle, h_rvalid is 1 and h_rdata holds the value d_rdata carried in the request cycle.
- R3: In narrow mode, a 2-byte write stores its low 16 data bits in the upper holding half when address bit 1 is 1, and in the lower holding half otherwise. The second 2-byte write to the same word issues one d_wr carrying {upper, lower}. The first write issues nothing.
- R4: A halfword access (read or write) whose word address differs from that of the previous halfword access of the same direction restarts the pairing, so that access counts as the first of a new pair.
- R5: The first 2-byte read of a pair issues one d_rd and latches the word. The second 2-byte read to that word issues no d_rd and returns data from the latch, even if the word changed downstream in between.
- R6: A 2-byte read returns bits 31:16 of the word when address bit 1 is 1, and bits 15:0 otherwise, in h_rdata[15:0] with h_rdata[31:16] zero.
- R7: The configuration word (byte offset 0x74) reads 0x00050004 after reset in wide mode (strap_narrow = 0) and 0x00050000 in narrow mode. Bit 2 equals the inverse of the strap.
- R8: A write to the configuration word with bit 0 clear sets the register to (data AND 0x0003F300), with bit 2 kept at its strapped value. It issues no d_wr.
- R9: A write to the configuration word with bit 0 set is a soft reset. It returns the configuration register to its reset value and clears both halfword pair counters.
- R10: An access with a size other than 4, or other than 2 in narrow mode, issues no strobe and no h_rvalid, and asserts h_err in the next cycle. A 2-byte access in wide mode is such an error.
- R11: Two 2-byte writes to the same half of one word still form a pair and commit. The other half carries whatever the holding register last held.
- R12: d_wr and d_rd are never asserted together, and each is asserted only in a cycle with h_req. The bench matches every strobe against an expected count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_narrow | input | 1 | 1 selects 16-bit host bus mode; captured at reset |
| h_req | input | 1 | Host access request, one cycle per access |
| h_we | input | 1 | 1 for write, 0 for read |
| h_size | input | 3 | Access size in bytes |
| h_addr | input | ADDR_W | Host byte address; low 8 bits decoded |
| h_wdata | input | 32 | Host write data; halfword in bits 15:0 |
| h_rdata | output | 32 | Read data, valid with h_rvalid |
| h_rvalid | output | 1 | Read data valid, one cycle after request |
| h_err | output | 1 | Bad access size, one cycle after request |
| d_wr | output | 1 | Downstream 32-bit write strobe |
| d_rd | output | 1 | Downstream 32-bit read strobe |
| d_addr | output | 8 | Downstream word-aligned byte address |
| d_wdata | output | 32 | Downstream write data |
| d_rdata | input | 32 | Downstream read data, combinational in the strobe cycle |

## Verification
The checker assumes that strap_narrow changes only while rst_n is low, because its error and mode checks compare against the live strap rather than the captured value. It also assumes that the register file answers d_rdata in the same cycle as d_rd. The bench changes the strap only inside a reset pulse and models the register file as a combinational-read memory. It spaces host requests one cycle apart, so every strobe count and every returned halfword can be attributed to a single access.

// File: rtl/hwb_pkg.sv
// Package: shared constants and types for the halfword bridge.
// Assumes a 32-bit downstream word and byte-count access sizes.
package hwb_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned HALF_W = WORD_W / 2;

    // Access sizes in bytes as presented on h_size
    localparam logic [2:0] SZ_HALF = 3'd2;
    localparam logic [2:0] SZ_WORD = 3'd4;

    // Configuration register layout
    localparam logic [WORD_W-1:0] CFG_BASE  = 32'h0005_0000;
    localparam logic [WORD_W-1:0] CFG_WMASK = 32'h0003_F300;
    localparam int unsigned       CFG_MODE_BIT = 2;
    localparam int unsigned       CFG_SRST_BIT = 0;

    // Indices of the two pair trackers
    localparam int unsigned TRK_WR = 0;
    localparam int unsigned TRK_RD = 1;
    localparam int unsigned TRK_N  = 2;

    typedef enum logic [1:0] {
        ACC_WIDE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_BAD  = 2'd2
    } acc_kind_e;

endpackage

// File: rtl/hwb_pair_track.sv
// Module: hwb_pair_track
// Tracks pairs of halfword accesses in one direction. It remembers the
// word address of the previous halfword access and whether one half of
// a pair is outstanding. 'second' flags, combinationally, that the
// current hit completes a pair. Assumes at most one hit per cycle.
module hwb_pair_track #(
    parameter int unsigned WA_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            hit,
    input  logic [WA_W-1:0] waddr,
    output logic            second
);

    logic [WA_W-1:0] prev_q;
    logic            pend_q;

    // A hit to the remembered word with one half pending closes the pair
    always_comb second = hit && pend_q && (prev_q == waddr);

    // Update the remembered word and pending flag on each halfword hit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            pend_q <= 1'b0;
        end else if (clr) begin
            pend_q <= 1'b0;
        end else if (hit) begin
            prev_q <= waddr;
            pend_q <= !second;
        end
    end

endmodule

// File: rtl/hwb_cfg_reg.sv
// Module: hwb_cfg_reg
// Configuration register owned by the bridge. It captures the bus mode
// strap at reset, reports it in one bit, keeps the writable field, and
// decodes a soft reset request from a write with the low bit set.
// Assumes the strap is stable while rst_n is high.
module hwb_cfg_reg
    import hwb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_narrow,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] cfg,
    output logic              mode_narrow,
    output logic              soft_rst
);

    logic              narrow_q;
    logic [WORD_W-1:0] cfg_q;
    logic [WORD_W-1:0] mode_bits;

    // Mode bit as it appears in the register: set in wide mode
    always_comb begin
        mode_bits = '0;
        mode_bits[CFG_MODE_BIT] = !narrow_q;
    end

    // Soft reset request decoded from a write with the reset bit set
    always_comb soft_rst = wr_en && wdata[CFG_SRST_BIT];

    // Capture the strap and maintain the register contents
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            narrow_q <= strap_narrow;
            cfg_q    <= CFG_BASE | (strap_narrow ? '0 : (WORD_W'(1) << CFG_MODE_BIT));
        end else if (soft_rst) begin
            cfg_q <= CFG_BASE | mode_bits;
        end else if (wr_en) begin
            cfg_q <= (wdata & CFG_WMASK) | mode_bits;
        end
    end

    assign cfg         = cfg_q;
    assign mode_narrow = narrow_q;

endmodule

// File: rtl/halfword_bridge.sv
// Module: halfword_bridge (top)
// Joins halfword host accesses into single 32-bit downstream accesses.
// Two halfword writes to one word produce one write strobe; two halfword
// reads of one word produce one read strobe, served from a latch.
// Word accesses pass through. Downstream read data must be valid
// combinationally in the strobe cycle; host read data follows one cycle
// after the request. Requires ADDR_W > WIN_BITS.
module halfword_bridge
    import hwb_pkg::*;
#(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned WIN_BITS   = 8,
    parameter int unsigned CFG_OFFSET = 'h74
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                strap_narrow,
    input  logic                h_req,
    input  logic                h_we,
    input  logic [2:0]          h_size,
    input  logic [ADDR_W-1:0]   h_addr,
    input  logic [WORD_W-1:0]   h_wdata,
    output logic [WORD_W-1:0]   h_rdata,
    output logic                h_rvalid,
    output logic                h_err,
    output logic                d_wr,
    output logic                d_rd,
    output logic [WIN_BITS-1:0] d_addr,
    output logic [WORD_W-1:0]   d_wdata,
    input  logic [WORD_W-1:0]   d_rdata
);

    localparam int unsigned     WA_W     = WIN_BITS - 2;
    localparam logic [WA_W-1:0] CFG_WORD = WA_W'(CFG_OFFSET >> 2);

    logic [WIN_BITS-1:0] addr_win;
    logic [WA_W-1:0]     waddr;
    logic                upper_sel;
    logic                cfg_hit;
    logic                unused_addr_hi;
    acc_kind_e           kind;

    logic [TRK_N-1:0]    trk_hit;
    logic [TRK_N-1:0]    trk_second;

    logic [HALF_W-1:0]   hold_lo_q;
    logic [HALF_W-1:0]   hold_hi_q;
    logic [WORD_W-1:0]   rd_latch_q;

    logic                commit_w;
    logic [WORD_W-1:0]   word_w;
    logic                fetch;
    logic [WORD_W-1:0]   fetched;
    logic [WORD_W-1:0]   rd_src;
    logic [WORD_W-1:0]   rd_word;

    logic [WORD_W-1:0]   cfg;
    logic                mode_narrow;
    logic                soft_rst;
    logic                cfg_we;

    logic [WORD_W-1:0]   rdata_q;
    logic                rvalid_q;
    logic                err_q;

    // Decode the address window and the target word
    always_comb begin
        addr_win  = h_addr[WIN_BITS-1:0];
        waddr     = addr_win[WIN_BITS-1:2];
        upper_sel = addr_win[1];
        cfg_hit   = (waddr == CFG_WORD);
    end
    assign unused_addr_hi = ^h_addr[ADDR_W-1:WIN_BITS];

    // Classify the access by size and bus mode
    always_comb begin
        kind = ACC_BAD;
        if (h_size == SZ_WORD)
            kind = ACC_WIDE;
        else if ((h_size == SZ_HALF) && mode_narrow)
            kind = ACC_HALF;
    end

    // Halfword hits per direction feed the pair trackers
    always_comb begin
        trk_hit[TRK_WR] = h_req && h_we  && (kind == ACC_HALF);
        trk_hit[TRK_RD] = h_req && !h_we && (kind == ACC_HALF);
    end

    // One pair tracker per direction
    for (genvar gi = 0; gi < TRK_N; gi++) begin : g_trk
        hwb_pair_track #(.WA_W(WA_W)) u_trk (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (soft_rst),
            .hit    (trk_hit[gi]),
            .waddr  (waddr),
            .second (trk_second[gi])
        );
    end

    // Store each written halfword in the half that address bit 1 selects
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_lo_q <= '0;
            hold_hi_q <= '0;
        end else if (trk_hit[TRK_WR]) begin
            if (upper_sel) hold_hi_q <= h_wdata[HALF_W-1:0];
            else           hold_lo_q <= h_wdata[HALF_W-1:0];
        end
    end

    // Build the committed write word from the new half and the held half
    always_comb begin
        commit_w = h_req && h_we && ((kind == ACC_WIDE) || trk_second[TRK_WR]);
        if (kind == ACC_WIDE)
            word_w = h_wdata;
        else if (upper_sel)
            word_w = {h_wdata[HALF_W-1:0], hold_lo_q};
        else
            word_w = {hold_hi_q, h_wdata[HALF_W-1:0]};
    end

    // Route a committed word to the config register or downstream
    always_comb begin
        cfg_we  = commit_w && cfg_hit;
        d_wr    = commit_w && !cfg_hit;
        d_wdata = word_w;
        d_addr  = {waddr, 2'b00};
    end

    // A read fetches unless it is the second half of a pair
    always_comb begin
        fetch   = h_req && !h_we &&
                  ((kind == ACC_WIDE) || ((kind == ACC_HALF) && !trk_second[TRK_RD]));
        d_rd    = fetch && !cfg_hit;
        fetched = cfg_hit ? cfg : d_rdata;
        rd_src  = trk_second[TRK_RD] ? rd_latch_q : fetched;
        if (kind == ACC_WIDE)
            rd_word = fetched;
        else if (upper_sel)
            rd_word = {{HALF_W{1'b0}}, rd_src[WORD_W-1:HALF_W]};
        else
            rd_word = {{HALF_W{1'b0}}, rd_src[HALF_W-1:0]};
    end

    // Latch the fetched word on the first halfword read of a pair
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_latch_q <= '0;
        else if (trk_hit[TRK_RD] && !trk_second[TRK_RD])
            rd_latch_q <= fetched;
    end

    // Register host-side read data, valid and error flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            rvalid_q <= h_req && !h_we && (kind != ACC_BAD);
            err_q    <= h_req && (kind == ACC_BAD);
            if (h_req && !h_we && (kind != ACC_BAD))
                rdata_q <= rd_word;
        end
    end

    hwb_cfg_reg u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .strap_narrow (strap_narrow),
        .wr_en        (cfg_we),
        .wdata        (word_w),
        .cfg          (cfg),
        .mode_narrow  (mode_narrow),
        .soft_rst     (soft_rst)
    );

    assign h_rdata  = rdata_q;
    assign h_rvalid = rvalid_q;
    assign h_err    = err_q;

endmodule

// File: rtl/hwb_checker.sv
// Module: hwb_checker
// Port-level properties of halfword_bridge, attached with bind.
// Assumes strap_narrow changes only while rst_n is low.
module hwb_checker
    import hwb_pkg::*;
#(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned WIN_BITS   = 8,
    parameter int unsigned CFG_OFFSET = 'h74
) (
    input logic                clk,
    input logic                rst_n,
    input logic                strap_narrow,
    input logic                h_req,
    input logic                h_we,
    input logic [2:0]          h_size,
    input logic [ADDR_W-1:0]   h_addr,
    input logic [WORD_W-1:0]   h_wdata,
    input logic [WORD_W-1:0]   h_rdata,
    input logic                h_rvalid,
    input logic                h_err,
    input logic                d_wr,
    input logic                d_rd,
    input logic [WIN_BITS-1:0] d_addr,
    input logic [WORD_W-1:0]   d_wdata,
    input logic [WORD_W-1:0]   d_rdata
);

    localparam int unsigned     WA_W     = WIN_BITS - 2;
    localparam logic [WA_W-1:0] CFG_WORD = WA_W'(CFG_OFFSET >> 2);

    logic is_wide, is_half, is_bad, at_cfg;

    // Classify the current request independently of the design
    always_comb begin
        is_wide = (h_size == SZ_WORD);
        is_half = (h_size == SZ_HALF) && strap_narrow;
        is_bad  = !is_wide && !is_half;
        at_cfg  = (h_addr[WIN_BITS-1:2] == CFG_WORD);
    end

    assert_wide_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        h_req && h_we && is_wide && !at_cfg |->
            d_wr && (d_wdata == h_wdata) && (d_addr == {h_addr[WIN_BITS-1:2], 2'b00}));

    assert_wide_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        h_req && !h_we && is_wide && !at_cfg |=> h_rvalid && (h_rdata == $past(d_rdata)));

    assert_half_zero_ext_R6: assert property (@(posedge clk) disable iff (!rst_n)
        h_req && !h_we && is_half |=> h_rvalid && (h_rdata[31:16] == 16'h0000));

    assert_cfg_mode_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        h_req && !h_we && is_wide && at_cfg |=> h_rdata[2] == !strap_narrow);

    assert_bad_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
        h_req && is_bad |=> h_err && !h_rvalid);

    assert_bad_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        h_req && is_bad |-> !d_wr && !d_rd);

    assert_strobe_owner_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (d_wr || d_rd) |-> h_req);

    assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(d_wr && d_rd));

endmodule

bind halfword_bridge hwb_checker #(
    .ADDR_W     (ADDR_W),
    .WIN_BITS   (WIN_BITS),
    .CFG_OFFSET (CFG_OFFSET)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .strap_narrow (strap_narrow),
    .h_req        (h_req),
    .h_we         (h_we),
    .h_size       (h_size),
    .h_addr       (h_addr),
    .h_wdata      (h_wdata),
    .h_rdata      (h_rdata),
    .h_rvalid     (h_rvalid),
    .h_err        (h_err),
    .d_wr         (d_wr),
    .d_rd         (d_rd),
    .d_addr       (d_addr),
    .d_wdata      (d_wdata),
    .d_rdata      (d_rdata)
);

// File: tb/halfword_bridge_test.sv
// Scoreboard bench: the read task queues expected data, a monitor pops
// and compares on each h_rvalid. Strobe counts come from a memory model.
module halfword_bridge_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] CFG = 16'h0074;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_narrow = 1'b0;
    logic        h_req = 1'b0;
    logic        h_we = 1'b0;
    logic [2:0]  h_size = 3'd4;
    logic [15:0] h_addr = '0;
    logic [31:0] h_wdata = '0;
    logic [31:0] h_rdata;
    logic        h_rvalid, h_err, d_wr, d_rd;
    logic [7:0]  d_addr;
    logic [31:0] d_wdata, d_rdata;

    logic [31:0] mem [0:63];
    int wr_cnt = 0;
    int rd_cnt = 0;
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    halfword_bridge uut (
        .clk(clk), .rst_n(rst_n), .strap_narrow(strap_narrow),
        .h_req(h_req), .h_we(h_we), .h_size(h_size), .h_addr(h_addr),
        .h_wdata(h_wdata), .h_rdata(h_rdata), .h_rvalid(h_rvalid),
        .h_err(h_err), .d_wr(d_wr), .d_rd(d_rd), .d_addr(d_addr),
        .d_wdata(d_wdata), .d_rdata(d_rdata)
    );

    // Register file model: combinational read, clocked write, strobe counts
    assign d_rdata = mem[d_addr[7:2]];
    initial for (int i = 0; i < 64; i++) mem[i] = '0;
    always @(posedge clk) begin
        if (d_wr) begin
            mem[d_addr[7:2]] <= d_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (d_rd) rd_cnt <= rd_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: compare each returned read against the queue head
    always @(negedge clk) begin
        if (rst_n && h_rvalid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected h_rvalid", h_rdata, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(h_rdata === e, t, h_rdata, e);
            end
        end
    end

    task automatic acc(input bit we, input logic [2:0] sz, input logic [15:0] a,
                       input logic [31:0] d);
        @(posedge clk); #1;
        h_req = 1'b1; h_we = we; h_size = sz; h_addr = a; h_wdata = d;
        @(posedge clk); #1;
        h_req = 1'b0;
    endtask

    task automatic wr(input logic [2:0] sz, input logic [15:0] a, input logic [31:0] d);
        acc(1'b1, sz, a, d);
    endtask

    task automatic rd(input logic [2:0] sz, input logic [15:0] a,
                      input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        acc(1'b0, sz, a, 32'h0);
    endtask

    task automatic do_reset(input bit narrow);
        @(posedge clk); #1;
        rst_n = 1'b0; strap_narrow = narrow;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic chk_cnt(input string req, input int ew, input int er);
        chk(wr_cnt == ew, {req, " write strobes"}, wr_cnt, ew);
        chk(rd_cnt == er, {req, " read strobes"}, rd_cnt, er);
    endtask

    initial begin
        int w0, r0;
        // ---- wide bus mode
        do_reset(1'b0);
        @(negedge clk);
        chk(!d_wr && !d_rd && !h_rvalid && !h_err, "reset outputs idle",
            {d_wr, d_rd, h_rvalid, h_err}, 32'h0);
        rd(3'd4, CFG, 32'h0005_0004, "R7 wide-mode cfg reset");
        wr(3'd4, CFG, 32'hFFFF_FFFA);
        rd(3'd4, CFG, 32'h0003_F304, "R8 cfg mask, bit2 kept");
        w0 = wr_cnt; r0 = rd_cnt;
        wr(3'd2, 16'h0010, 32'h0000_1234);
        chk(h_err === 1'b1, "R10 halfword in wide mode err", h_err, 1);
        chk_cnt("R10 wide-mode halfword", w0, r0);

        // ---- narrow bus mode
        do_reset(1'b1);
        rd(3'd4, CFG, 32'h0005_0000, "R7 narrow-mode cfg reset");
        w0 = wr_cnt; r0 = rd_cnt;
        wr(3'd4, 16'h0010, 32'hDEAD_BEEF);
        chk_cnt("R1 wide write", w0 + 1, r0);
        rd(3'd4, 16'h0010, 32'hDEAD_BEEF, "R2 wide read");
        chk_cnt("R2 wide read", w0 + 1, r0 + 1);
        wr(3'd4, 16'h0320, 32'h5A5A_0F0F);
        rd(3'd4, 16'h0020, 32'h5A5A_0F0F, "R1 high address bits ignored");
        wr(3'd4, 16'h0050, 32'h0000_0000);

        // R3 lower then upper
        w0 = wr_cnt;
        wr(3'd2, 16'h0040, 32'h0000_1111);
        chk(wr_cnt == w0, "R3 first half no strobe", wr_cnt, w0);
        wr(3'd2, 16'h0042, 32'h0000_2222);
        chk(wr_cnt == w0 + 1, "R3 pair one strobe", wr_cnt, w0 + 1);
        rd(3'd4, 16'h0040, 32'h2222_1111, "R3 merged word");
        // R3 upper then lower
        wr(3'd2, 16'h0046, 32'h0000_AAAA);
        wr(3'd2, 16'h0044, 32'h0000_BBBB);
        rd(3'd4, 16'h0044, 32'hAAAA_BBBB, "R3 reversed order");

        // R4 address change restarts the write pair
        w0 = wr_cnt;
        wr(3'd2, 16'h0050, 32'h0000_3333);
        wr(3'd2, 16'h0058, 32'h0000_4444);
        chk(wr_cnt == w0, "R4 new word restarts pair", wr_cnt, w0);
        wr(3'd2, 16'h005A, 32'h0000_5555);
        chk(wr_cnt == w0 + 1, "R4 pair commits once", wr_cnt, w0 + 1);
        rd(3'd4, 16'h0058, 32'h5555_4444, "R4 committed word");
        rd(3'd4, 16'h0050, 32'h0000_0000, "R4 abandoned word untouched");

        // R11 same half twice
        wr(3'd2, 16'h0062, 32'h0000_7777);
        wr(3'd2, 16'h0062, 32'h0000_8888);
        rd(3'd4, 16'h0060, 32'h8888_4444, "R11 stale lower half");

        // R5/R6 halfword reads served from the latch
        wr(3'd4, 16'h0070, 32'hCAFE_1234);
        r0 = rd_cnt;
        rd(3'd2, 16'h0070, 32'h0000_1234, "R6 lower half");
        chk(rd_cnt == r0 + 1, "R5 first half fetches", rd_cnt, r0 + 1);
        wr(3'd4, 16'h0070, 32'h0000_0000);
        rd(3'd2, 16'h0072, 32'h0000_CAFE, "R5 second half from latch");
        chk(rd_cnt == r0 + 1, "R5 second half no fetch", rd_cnt, r0 + 1);
        rd(3'd2, 16'h0012, 32'h0000_DEAD, "R6 upper half first");
        rd(3'd2, 16'h0010, 32'h0000_BEEF, "R6 lower half from latch");
        chk(rd_cnt == r0 + 2, "R5 upper-first pair one fetch", rd_cnt, r0 + 2);

        // R4 read address change restarts the read pair
        rd(3'd2, 16'h0010, 32'h0000_BEEF, "R4 read pair start");
        rd(3'd2, 16'h0022, 32'h0000_5A5A, "R4 read new word");
        chk(rd_cnt == r0 + 4, "R4 read restart fetches", rd_cnt, r0 + 4);

        // R9 soft reset clears pending halves
        w0 = wr_cnt;
        wr(3'd2, 16'h0060, 32'h0000_9999);
        wr(3'd4, CFG, 32'hFFFF_FFFE);
        rd(3'd4, CFG, 32'h0003_F300, "R8 narrow cfg write");
        chk(wr_cnt == w0, "R8 cfg write no strobe", wr_cnt, w0);
        wr(3'd4, CFG, 32'h0000_0001);
        rd(3'd4, CFG, 32'h0005_0000, "R9 cfg back to reset");
        wr(3'd2, 16'h0062, 32'h0000_1212);
        chk(wr_cnt == w0, "R9 write pair cleared", wr_cnt, w0);
        r0 = rd_cnt;
        rd(3'd2, 16'h0020, 32'h0000_0F0F, "R9 read after soft reset");
        chk(rd_cnt == r0 + 1, "R9 read pair cleared", rd_cnt, r0 + 1);

        // R10 bad sizes in narrow mode
        w0 = wr_cnt; r0 = rd_cnt;
        wr(3'd1, 16'h0010, 32'h0000_00FF);
        chk(h_err === 1'b1, "R10 size1 write err", h_err, 1);
        acc(1'b0, 3'd3, 16'h0010, 32'h0);
        chk(h_err === 1'b1, "R10 size3 read err", h_err, 1);
        chk_cnt("R10 bad size", w0, r0);
        rd(3'd4, 16'h0010, 32'hDEAD_BEEF, "R10 word unchanged");
        chk(rd_cnt == r0 + 1, "R12 one strobe per read", rd_cnt, r0 + 1);

        repeat (3) @(posedge clk);
        chk(exp_q.size() == 0, "R2 all reads returned", exp_q.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog ends a hung run as a failure
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R12 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule